// File: doc/BRIEF.md
# Eight-Pin GPIO Port Register Block

This block holds the control state of one eight-pin general-purpose I/O port behind a simple memory-mapped bus (word address, write data, write strobe, registered read data). Three control registers exist per port: a per-pin GPIO select, a per-pin drive enable and a per-pin output level. A fourth, read-only register returns the synchronized pad input levels.

The three control registers each have two write addresses. At the plain address a write replaces the whole register. At the alias address the upper half of the data word is a per-pin change mask and the lower half holds the new levels. Only the selected pins change, so software can update a single pin without reading first. To drive a pin, software sets its level, then its drive enable, then its GPIO select. Clearing the GPIO select hands the pin back to its other function and stops driving it.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset all control registers are 0, `pad_oe` and `pad_out` are 0, and reads of the control registers return 0.
- R2: Word addresses are: GPIO select 0x00, drive enable 0x04, output level 0x08 and input 0x0C. The masked aliases sit at 0x20, 0x24 and 0x28. `bus_rdata` is registered and shows the register chosen by the address presented in the cycle before.
- R3: A plain write stores `bus_wdata[7:0]`. Higher data bits are ignored, and reads return the value in bits 7:0 with all higher bits 0.
- R4: On a masked write, `bus_wdata[8+i]` selects pin i and `bus_wdata[i]` is its new value. Pins whose select bit is 0 keep their value.
- R5: A read of a masked alias returns the corresponding plain register in bits 7:0 and 0 above.
- R6: `pad_oe[i]` is 1 only when both the GPIO select bit and the drive enable bit of pin i are 1. It changes at the same clock edge as the register write.
- R7: `pad_out` equals the output level register and changes at the edge that writes it.
- R8: The input register is fed through a two-flop synchronizer. A `pad_in` change made before edge k is not visible in `bus_rdata` after edge k+1, and is visible after edge k+2 while the input address is held.
- R9: Writes to the input address 0x0C, to 0x2C, or to any unmapped address change no register and no pad output. Reads of unmapped addresses return 0.
- R10: Clearing a pin's GPIO select bit drops its `pad_oe` while its drive enable and output level bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad drive enables |

## Verification
A register write takes effect at the edge that sees the strobe. `pad_out` and `pad_oe` therefore change at that same edge. A read returns data one edge after the address is presented. A pad input reaches `bus_rdata` three edges after it changes. Each bench task drives its inputs on the falling edge and samples on the falling edge that follows the edge where the result is due. For the input path, the bench also samples one edge early to show the value has not yet arrived.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int IDX_CFG = 0;
  localparam int IDX_OE  = 1;
  localparam int IDX_OUT = 2;
  localparam int NUM_RW  = 3;
  localparam int IDX_IN  = 3;
  localparam int WORD_STEP = 4;

  function automatic int unsigned plain_word(input int unsigned idx);
    return idx * WORD_STEP;
  endfunction
endpackage

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_full,
  input  logic            wr_mask,
  input  logic [PINS-1:0] wval,
  input  logic [PINS-1:0] wsel,
  output logic [PINS-1:0] q,
  output logic [PINS-1:0] nxt
);
  always_comb begin
    if (wr_full)      nxt = wval;
    else if (wr_mask) nxt = (q & ~wsel) | (wval & wsel);
    else              nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PINS   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] d,
  output logic [PINS-1:0] q
);
  logic [STAGES-1:0][PINS-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port
  import gpio_port_pkg::*;
#(
  parameter int PINS      = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int MASK_BASE = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NUM_RW-1:0][PINS-1:0]   regs,
  input  logic [PINS-1:0]               in_sync,
  output logic [DATA_W-1:0]             rdata
);
  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    for (int r = 0; r < NUM_RW; r++) begin
      if (addr == ADDR_W'(plain_word(r)) ||
          addr == ADDR_W'(MASK_BASE + plain_word(r)))
        rd_nxt[PINS-1:0] = regs[r];
    end
    if (addr == ADDR_W'(plain_word(IDX_IN)))
      rd_nxt[PINS-1:0] = in_sync;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int MASK_BASE   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  logic [NUM_RW-1:0][PINS-1:0] reg_q;
  logic [NUM_RW-1:0][PINS-1:0] reg_nxt;
  logic [PINS-1:0]             in_s;
  logic [PINS-1:0]             wr_val;
  logic [PINS-1:0]             wr_sel;

  assign wr_val = bus_wdata[PINS-1:0];
  assign wr_sel = bus_wdata[2*PINS-1:PINS];

  for (genvar r = 0; r < NUM_RW; r++) begin : g_reg
    logic hit_full, hit_mask;
    assign hit_full = bus_we && (bus_addr == ADDR_W'(plain_word(r)));
    assign hit_mask = bus_we && (bus_addr == ADDR_W'(MASK_BASE + plain_word(r)));
    gpio_mask_reg #(.PINS(PINS)) u_reg (
      .clk     (clk),
      .rst     (rst),
      .wr_full (hit_full),
      .wr_mask (hit_mask),
      .wval    (wr_val),
      .wsel    (wr_sel),
      .q       (reg_q[r]),
      .nxt     (reg_nxt[r])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) pad_oe <= '0;
    else     pad_oe <= reg_nxt[IDX_CFG] & reg_nxt[IDX_OE];
  end

  assign pad_out = reg_q[IDX_OUT];

  gpio_in_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (in_s)
  );

  gpio_rd_port #(
    .PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MASK_BASE(MASK_BASE)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .regs    (reg_q),
    .in_sync (in_s),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
  parameter int PINS        = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int MASK_BASE   = 32,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [PINS-1:0]   pad_in,
  input logic [PINS-1:0]   pad_out,
  input logic [PINS-1:0]   pad_oe
);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_IN    = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_OUT_M = ADDR_W'(MASK_BASE + 8);

  logic [PINS-1:0] w_val, w_sel;
  assign w_val = bus_wdata[PINS-1:0];
  assign w_sel = bus_wdata[2*PINS-1:PINS];

  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  a_r7_plain_out: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_OUT) |=> (pad_out == $past(w_val)));

  a_r4_mask_keep: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_OUT_M) |=>
      ((pad_out & ~$past(w_sel)) == ($past(pad_out) & ~$past(w_sel))));

  a_r4_mask_set: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_OUT_M) |=>
      ((pad_out & $past(w_sel)) == ($past(w_val) & $past(w_sel))));

  a_r10_cfg_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_CFG && w_val == '0) |=> (pad_oe == '0));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!bus_we) |=> ($stable(pad_out) && $stable(pad_oe)));

  a_r8_sync_delay: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4 && $past(bus_addr) == A_IN) |->
      (bus_rdata[PINS-1:0] == $past(pad_in, 3)));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(
  .PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .MASK_BASE(MASK_BASE), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/gpio_port_regs_bench.sv
`timescale 1ns/1ps
module gpio_port_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_port_regs u_gpio_port_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 pad_oe", {24'h0, pad_oe}, 32'h0);
    check("R1 pad_out", {24'h0, pad_out}, 32'h0);
    bus_read(6'h00, d); check("R1 cfg", d, 32'h0);
    bus_read(6'h04, d); check("R1 oe", d, 32'h0);
    bus_read(6'h08, d); check("R1 out", d, 32'h0);
  endtask

  task automatic t_plain;
    logic [31:0] d;
    bus_write(6'h08, 32'hDEADFFA5);
    check("R7 R3 pad_out plain", {24'h0, pad_out}, 32'hA5);
    bus_read(6'h08, d);
    check("R2 R3 read out", d, 32'h000000A5);
  endtask

  task automatic t_masked;
    bus_write(6'h28, 32'h00000FF0);
    check("R4 mask low nibble", {24'h0, pad_out}, 32'hA0);
    bus_write(6'h28, 32'h0000C341);
    check("R4 mask mixed", {24'h0, pad_out}, 32'h61);
  endtask

  task automatic t_alias_read;
    logic [31:0] d;
    bus_read(6'h28, d);
    check("R5 alias read", d, 32'h00000061);
  endtask

  task automatic t_oe_gate;
    logic [31:0] d;
    bus_write(6'h04, 32'h000000FF);
    check("R6 oe without cfg", {24'h0, pad_oe}, 32'h0);
    bus_write(6'h20, 32'h00000F05);
    check("R6 oe with cfg", {24'h0, pad_oe}, 32'h05);
    bus_write(6'h20, 32'h00000100);
    check("R10 cfg clear drops oe", {24'h0, pad_oe}, 32'h04);
    bus_read(6'h04, d); check("R10 oe kept", d, 32'hFF);
    bus_read(6'h24, d); check("R5 oe alias read", d, 32'hFF);
    check("R10 out kept", {24'h0, pad_out}, 32'h61);
  endtask

  task automatic t_input_sync;
    @(negedge clk);
    bus_addr = 6'h0C;
    repeat (4) @(negedge clk);
    check("R8 input idle", bus_rdata, 32'h0);
    pad_in = 8'h3C;
    @(negedge clk); @(negedge clk);
    check("R8 not yet visible", bus_rdata, 32'h0);
    @(negedge clk);
    check("R8 visible after sync", bus_rdata, 32'h3C);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    bus_write(6'h0C, 32'hFFFFFFFF);
    bus_write(6'h2C, 32'h0000FFFF);
    bus_write(6'h3F, 32'h0000FFFF);
    check("R9 pad_out held", {24'h0, pad_out}, 32'h61);
    check("R9 pad_oe held", {24'h0, pad_oe}, 32'h04);
    bus_read(6'h00, d); check("R9 cfg held", d, 32'h04);
    bus_read(6'h3F, d); check("R9 unmapped read", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_plain;
    t_masked;
    t_alias_read;
    t_oe_gate;
    t_input_sync;
    t_ignored;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule